// File: doc/BRIEF.md
# Field-Loadable Two-Plane Logic Array

This block is a small sum-of-products engine in which both planes can be set. A set of shared product terms is formed from the true and complemented forms of the primary inputs. Any term can be routed to any output. Each output then passes through a selectable inversion, so a function or its complement can come from the same shared terms.

The pattern of connections is a single bit string. It is shifted into a shadow register one bit per clock and then made live by a one-cycle commit strobe. Because of this, evaluation never sees a half-written pattern. A sticky status pin reports that at least one pattern has been made live since reset.

Input vectors arrive on a valid/ready stream. Results leave on a second valid/ready stream through a single output register. A vector is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the consumer takes the held result in the same cycle. While `out_valid` is high and `out_ready` is low, the held result and `out_valid` do not change, and no new vector is accepted. The configuration pins and the status pin are plain signals with no handshake.

Top module: `pla_core`

## Requirements
- R1: After reset, `out_valid` and `cfg_valid` are 0 and `in_ready` is 1. The live pattern has every AND fuse set to 1, every OR fuse 0 and every inversion bit 0, so every accepted vector produces `out_data` = 0 until a commit.
- R2: While `cfg_load_en` is 1, each clock shifts `cfg_bit` into the shadow register at bit 0 and moves the older bits up, so the first bit sent ends at bit 38 (most significant bit first). While `cfg_load_en` is 0, `cfg_bit` has no effect on the shadow contents.
- R3: A clock edge with `cfg_commit` high copies the whole 39-bit shadow into the live pattern in that one cycle. Shifting without a commit leaves the results unchanged.
- R4: Pattern bits 38..15 are AND fuses; term t uses bits 15+6t .. 20+6t. Within a term, offset 2i is the true literal of input i and offset 2i+1 is its complement. A 1 includes the literal and a 0 leaves it out. A term is the AND of its included literals, and a term with no included literal is 1.
- R5: A term that includes both the true and the complemented literal of one input is 0 for every input vector.
- R6: Pattern bit 3+4o+t (bits 14..3) connects term t to output o. Output o is the OR of its connected terms, and is 0 before inversion if no term is connected.
- R7: Pattern bit o (bits 2..0) inverts output o: `out_data[o]` is the OR result XOR that bit.
- R8: A vector accepted at a clock edge appears on `out_data` with `out_valid` high right after that edge. The result uses the live pattern as it stood before that edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and both `out_valid` and `out_data` hold. When `out_ready` is 1, a new vector may be accepted in the same cycle.
- R10: `cfg_valid` rises after the first commit and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take an input vector |
| in_data | input | 3 | Primary input vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 3 | Evaluated outputs |
| cfg_load_en | input | 1 | Shift enable for the shadow pattern |
| cfg_bit | input | 1 | Serial pattern bit |
| cfg_commit | input | 1 | Copy the shadow pattern into the live pattern |
| cfg_valid | output | 1 | A pattern has been committed since reset |

## Verification
The bench builds the block with its defaults: 3 inputs, 3 outputs and 4 terms, giving a 39-bit pattern and only 8 input vectors. That size lets every loaded pattern be checked against all input vectors.

The patterns cover each single literal in isolation, each input's contradictory literal pair, each term-to-output route on its own, inversion alone, and a run of pseudo-random patterns. Stalls on the output stream and a second reset are also exercised.

// File: rtl/pla_pkg.sv
package pla_pkg;
  function automatic int unsigned and_bits(input int unsigned n_in, input int unsigned n_term);
    return n_term * 2 * n_in;
  endfunction

  function automatic int unsigned or_bits(input int unsigned n_out, input int unsigned n_term);
    return n_out * n_term;
  endfunction

  function automatic int unsigned map_bits(input int unsigned n_in, input int unsigned n_out,
                                           input int unsigned n_term);
    return and_bits(n_in, n_term) + or_bits(n_out, n_term) + n_out;
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int unsigned MAP_W = 39,
  parameter logic [MAP_W-1:0] RESET_MAP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             load_bit,
  input  logic             commit,
  output logic [MAP_W-1:0] active_map,
  output logic             cfg_valid
);
  logic [MAP_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      active_map <= RESET_MAP;
      cfg_valid  <= 1'b0;
    end else begin
      if (load_en) shadow_q <= {shadow_q[MAP_W-2:0], load_bit};
      if (commit) begin
        active_map <= shadow_q;
        cfg_valid  <= 1'b1;
      end
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(shadow_q)); // R2
  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_map)); // R3
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> active_map == $past(shadow_q)); // R3
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid); // R10
  AST_VALID_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cfg_valid); // R10
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_TERM = 4,
  localparam int unsigned LIT_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]         x,
  input  logic [N_TERM*LIT_W-1:0] fuses,
  output logic [N_TERM-1:0]       terms
);
  logic [LIT_W-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = x[i];
    assign lits[2*i+1] = ~x[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    // a literal left out (fuse 0) forces its slot to 1
    assign terms[t] = &(lits | ~fuses[t*LIT_W +: LIT_W]);
  end
endmodule

// File: rtl/pla_or_xor.sv
module pla_or_xor #(
  parameter int unsigned N_OUT  = 3,
  parameter int unsigned N_TERM = 4
) (
  input  logic [N_TERM-1:0]       terms,
  input  logic [N_OUT*N_TERM-1:0] or_fuses,
  input  logic [N_OUT-1:0]        inv_fuses,
  output logic [N_OUT-1:0]        y
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign y[o] = (|(terms & or_fuses[o*N_TERM +: N_TERM])) ^ inv_fuses[o];
  end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_OUT  = 3,
  parameter int unsigned N_TERM = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N_IN-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N_OUT-1:0] out_data,
  input  logic             cfg_load_en,
  input  logic             cfg_bit,
  input  logic             cfg_commit,
  output logic             cfg_valid
);
  import pla_pkg::*;

  localparam int unsigned AND_W = and_bits(N_IN, N_TERM);
  localparam int unsigned OR_W  = or_bits(N_OUT, N_TERM);
  localparam int unsigned MAP_W = map_bits(N_IN, N_OUT, N_TERM);
  localparam logic [MAP_W-1:0] RST_MAP = {{AND_W{1'b1}}, {(MAP_W-AND_W){1'b0}}};

  logic [MAP_W-1:0]  live_map;
  logic [N_TERM-1:0] terms;
  logic [N_OUT-1:0]  y;
  logic              accept;

  pla_cfg_store #(.MAP_W(MAP_W), .RESET_MAP(RST_MAP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_en(cfg_load_en), .load_bit(cfg_bit),
    .commit(cfg_commit), .active_map(live_map), .cfg_valid(cfg_valid)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .x(in_data), .fuses(live_map[MAP_W-1 -: AND_W]), .terms(terms)
  );

  pla_or_xor #(.N_OUT(N_OUT), .N_TERM(N_TERM)) u_or (
    .terms(terms), .or_fuses(live_map[N_OUT +: OR_W]),
    .inv_fuses(live_map[N_OUT-1:0]), .y(y)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= y;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

// File: tb/pla_core_tb_top.sv
module pla_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [2:0] in_data = '0;
  logic cfg_load_en = 1'b0, cfg_bit = 1'b0, cfg_commit = 1'b0;
  logic in_ready, out_valid, cfg_valid;
  logic [2:0] out_data;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pla_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cfg_load_en(cfg_load_en), .cfg_bit(cfg_bit),
    .cfg_commit(cfg_commit), .cfg_valid(cfg_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic [38:0] m, input logic [2:0] x);
    logic [3:0] tm;
    logic [2:0] y;
    for (int t = 0; t < 4; t++) begin
      tm[t] = 1'b1;
      for (int i = 0; i < 3; i++) begin
        if (m[15 + 6*t + 2*i] && !x[i]) tm[t] = 1'b0;
        if (m[15 + 6*t + 2*i + 1] && x[i]) tm[t] = 1'b0;
      end
    end
    for (int o = 0; o < 3; o++) y[o] = (|(tm & m[3 + 4*o +: 4])) ^ m[o];
    return y;
  endfunction

  task automatic shift_map(input logic [38:0] m);
    for (int b = 38; b >= 0; b--) begin
      @(negedge clk); cfg_load_en = 1'b1; cfg_bit = m[b];
    end
    @(negedge clk); cfg_load_en = 1'b0;
  endtask

  task automatic commit;
    @(negedge clk); cfg_commit = 1'b1;
    @(negedge clk); cfg_commit = 1'b0;
  endtask

  task automatic sweep(input string tag, input logic [38:0] m);
    for (int x = 0; x < 8; x++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 3'(x); out_ready = 1'b1;
      @(negedge clk); in_valid = 1'b0;
      chk(tag, {out_valid, out_data}, {1'b1, model(m, 3'(x))});
    end
  endtask

  task automatic load_run(input string tag, input logic [38:0] m);
    shift_map(m); commit(); sweep(tag, m);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [38:0] m, seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {out_valid, cfg_valid, in_ready}, 3'b001);
    sweep("R1 reset map gives 0", {{24{1'b1}}, 15'd0});
    // R3: shifted but uncommitted map must not show
    m = {24'hFFFFFF & ~24'h3F, 12'hFFF, 3'b000};
    shift_map(m);
    sweep("R3 no commit no change", {{24{1'b1}}, 15'd0});
    chk("R10 still invalid", cfg_valid, 0);
    // R2: cfg_bit toggling with load low is ignored
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); cfg_bit = k[0];
    end
    commit();
    chk("R10 valid after commit", cfg_valid, 1);
    sweep("R2 R3 committed map", m);
    // R4: single literal per term 0, other terms contradictory
    for (int l = 0; l < 6; l++) begin
      m = '0;
      m[15 + l] = 1'b1;
      for (int t = 1; t < 4; t++) m[15 + 6*t +: 2] = 2'b11;
      for (int o = 0; o < 3; o++) m[3 + 4*o] = 1'b1;
      load_run("R4 literal", m);
    end
    m = {24'd0, 12'h111, 3'b000};
    load_run("R4 empty term is 1", m);
    // R5: contradictory pair
    for (int i = 0; i < 3; i++) begin
      m = '0;
      m[15 + 2*i +: 2] = 2'b11;
      m[3 +: 12] = 12'h111;
      load_run("R5 contradiction", m);
    end
    // R6: each term routed alone to each output
    for (int t = 0; t < 4; t++)
      for (int o = 0; o < 3; o++) begin
        m = '0;
        for (int u = 0; u < 4; u++) m[15 + 6*u +: 2] = (u == t) ? 2'b01 : 2'b11;
        m[3 + 4*o + t] = 1'b1;
        load_run("R6 routing", m);
      end
    // R7: inversion only, then pseudo-random maps
    load_run("R7 inversion only", {36'd0, 3'b101});
    seed = 39'h5A5A_1234_C;
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s < 11; s++) seed = {seed[37:0], seed[38] ^ seed[34]};
      load_run("R7 random map", seed);
    end
    chk("R10 stays high", cfg_valid, 1);
    // R9: back-pressure
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_data = 3'd5;
    @(negedge clk); in_data = 3'd2;
    chk("R8 first result", {out_valid, out_data}, {1'b1, model(seed, 3'd5)});
    chk("R9 not ready when full", in_ready, 0);
    repeat (3) @(negedge clk);
    chk("R9 hold under stall", {out_valid, out_data}, {1'b1, model(seed, 3'd5)});
    out_ready = 1'b1;
    #1 chk("R9 ready when drained", in_ready, 1);
    @(negedge clk); in_valid = 1'b0;
    chk("R9 next taken same cycle", {out_valid, out_data}, {1'b1, model(seed, 3'd2)});
    @(negedge clk);
    chk("R8 valid drops when idle", out_valid, 0);
    // R1 R10: reset clears status and restores default map
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 cleared by reset", cfg_valid, 0);
    sweep("R1 default map after reset", {{24{1'b1}}, 15'd0});
    finish_up();
  end
endmodule